// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Flag

This block is the shift and rotate slice of a 32-bit datapath. It takes one data operand and a shift count and returns the shifted or rotated word in the same cycle. The count comes either from a register operand or from a short immediate field, and an input chooses which one. Five operations work on the 32-bit word alone: logical left shift, logical right shift, arithmetic right shift, rotate left and rotate right. Two more rotate the word together with the stored carry bit, so the carry acts as a 33rd bit of the ring.

Every operation also produces negative, zero and carry flags. The carry flag is kept in a one-bit status register. That register feeds the carry rotates and the zero-count cases, and it loads the new carry only when the write strobe is high at a rising clock edge. The result and the flag outputs are combinational. The only state in the block is the carry register.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 000 (logical left shift by k) fills the k vacated low bits with zeros. For k from 1 to 31, flag_c equals operand bit 32-k.
- R2: Operation code 001 (logical right shift by k) fills the k vacated high bits with zeros. For k from 1 to 31, flag_c equals operand bit k-1.
- R3: Operation code 010 (arithmetic right shift by k) copies operand bit 31 into every vacated high bit. For k from 1 to 31, flag_c equals operand bit k-1.
- R4: Operation code 011 rotates left by k and code 100 rotates right by k. Bits leaving one end re-enter at the other end. For a nonzero k, flag_c equals result bit 0 after a left rotate and result bit 31 after a right rotate.
- R5: Operation code 101 rotates left and code 110 rotates right the 33-bit ring formed by the stored carry bit placed above operand bit 31. The new carry is the ring's top bit, and the count is taken modulo 33.
- R6: When use_imm is 1 the count is amt_imm, zero-extended. When use_imm is 0 the count is amt_reg. Codes 000 to 100 use only the low 5 bits of the count.
- R7: When the effective count is zero, result equals the operand and flag_c equals the stored carry.
- R8: flag_n equals result bit 31, and flag_z is 1 exactly when the whole result is zero.
- R9: carry_q takes the value of flag_c at a rising clock edge where flag_we is 1. It holds its value at every other edge.
- R10: A synchronous active-high rst clears carry_q to 0 at the next rising edge.
- R11: Operation code 111 passes the operand to result unchanged, and flag_c equals the stored carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry register |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| src_a | input | 32 | Data operand |
| amt_reg | input | 32 | Count taken from a register operand |
| amt_imm | input | 6 | Count taken from the immediate field |
| use_imm | input | 1 | 1 selects amt_imm, 0 selects amt_reg |
| flag_we | input | 1 | Write strobe for the carry register |
| result | output | 32 | Shifted or rotated word |
| flag_n | output | 1 | Negative flag of the result |
| flag_z | output | 1 | Zero flag of the result |
| flag_c | output | 1 | Carry produced by this operation |
| carry_q | output | 1 | Stored carry flag |

## Verification
The assertions check on every cycle the properties that hold for any operand:
- the carry register loads flag_c under the strobe, holds without it, and clears on reset;
- a zero effective count and the pass-through code leave both the word and the carry untouched;
- a left shift always clears its vacated low bits;
- an arithmetic right shift keeps the sign bit.

Only the bench's scenarios can show the exact bit that lands in the carry for each count, the wrap of bits in both rotate directions, and the modulo-33 handling of large counts in the ring rotates. The same holds for the stored carry feeding back into a later ring rotate. The bench compares these against a bit-by-bit step model.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 6;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int RING_W  = DATA_W + 1;
    localparam int RCNT_W  = $clog2(RING_W + 1);

    typedef enum logic [2:0] {
        OP_LSL  = 3'b000,
        OP_LSR  = 3'b001,
        OP_ASR  = 3'b010,
        OP_ROL  = 3'b011,
        OP_ROR  = 3'b100,
        OP_ROLC = 3'b101,
        OP_RORC = 3'b110,
        OP_PASS = 3'b111
    } sru_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } sru_res_t;

    // Plain shifts and rotates within the data word.
    function automatic sru_res_t f_plain(input sru_op_e op,
                                         input logic [DATA_W-1:0] a,
                                         input logic [SHAMT_W-1:0] k,
                                         input logic cin);
        sru_res_t                   r;
        logic [DATA_W:0]            w1;
        logic signed [DATA_W:0]     s1;
        logic [2*DATA_W-1:0]        w2;
        r  = '{value: a, carry: cin};
        w1 = '0;
        s1 = '0;
        w2 = '0;
        unique case (op)
            OP_LSL: begin
                w1 = {1'b0, a} << k;
                r.value = w1[DATA_W-1:0];
                r.carry = w1[DATA_W];
            end
            OP_LSR: begin
                w1 = {a, 1'b0} >> k;
                r.value = w1[DATA_W:1];
                r.carry = w1[0];
            end
            OP_ASR: begin
                s1 = {a, 1'b0};
                s1 = s1 >>> k;
                r.value = s1[DATA_W:1];
                r.carry = s1[0];
            end
            OP_ROL: begin
                w2 = {a, a} << k;
                r.value = w2[2*DATA_W-1:DATA_W];
                r.carry = w2[DATA_W];
            end
            OP_ROR: begin
                w2 = {a, a} >> k;
                r.value = w2[DATA_W-1:0];
                r.carry = w2[DATA_W-1];
            end
            default: r = '{value: a, carry: cin};
        endcase
        if (k == '0) r.carry = cin;
        return r;
    endfunction

    // Rotates through the carry: {cin, a} forms one ring.
    function automatic sru_res_t f_ring(input logic left,
                                        input logic [DATA_W-1:0] a,
                                        input logic [RCNT_W-1:0] k,
                                        input logic cin);
        logic [2*RING_W-1:0] w;
        logic [RING_W-1:0]   n;
        sru_res_t            r;
        if (left) begin
            w = {cin, a, cin, a} << k;
            n = w[2*RING_W-1:RING_W];
        end else begin
            w = {cin, a, cin, a} >> k;
            n = w[RING_W-1:0];
        end
        r.carry = n[DATA_W];
        r.value = n[DATA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/sru_amount.sv
module sru_amount
    import sru_pkg::*;
(
    input  logic [DATA_W-1:0]  amt_reg,
    input  logic [IMM_W-1:0]   amt_imm,
    input  logic               use_imm,
    output logic [SHAMT_W-1:0] plain_amt,
    output logic [RCNT_W-1:0]  ring_amt
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] ring_mod;

    always_comb begin
        raw       = use_imm ? {{(DATA_W-IMM_W){1'b0}}, amt_imm} : amt_reg;
        ring_mod  = raw % DATA_W'(RING_W);
        plain_amt = raw[SHAMT_W-1:0];
        ring_amt  = ring_mod[RCNT_W-1:0];
    end
endmodule

// File: rtl/sru_plain_shifter.sv
module sru_plain_shifter
    import sru_pkg::*;
(
    input  sru_op_e            op,
    input  logic [DATA_W-1:0]  src,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               cin,
    output sru_res_t           res
);
    always_comb res = f_plain(op, src, amt, cin);
endmodule

// File: rtl/sru_ring_rotator.sv
module sru_ring_rotator
    import sru_pkg::*;
(
    input  logic               left,
    input  logic [DATA_W-1:0]  src,
    input  logic [RCNT_W-1:0]  amt,
    input  logic               cin,
    output sru_res_t           res
);
    always_comb res = f_ring(left, src, amt, cin);
endmodule

// File: rtl/sru_carry_reg.sv
module sru_carry_reg (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_sel,
    input  logic [31:0]       src_a,
    input  logic [31:0]       amt_reg,
    input  logic [5:0]        amt_imm,
    input  logic              use_imm,
    input  logic              flag_we,
    output logic [31:0]       result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              carry_q
);
    sru_op_e            op;
    logic [SHAMT_W-1:0] plain_amt;
    logic [RCNT_W-1:0]  ring_amt;
    sru_res_t           plain_res;
    sru_res_t           ring_res;
    sru_res_t           sel_res;

    assign op = sru_op_e'(op_sel);

    sru_amount u_amount (
        .amt_reg   (amt_reg),
        .amt_imm   (amt_imm),
        .use_imm   (use_imm),
        .plain_amt (plain_amt),
        .ring_amt  (ring_amt)
    );

    sru_plain_shifter u_plain (
        .op  (op),
        .src (src_a),
        .amt (plain_amt),
        .cin (carry_q),
        .res (plain_res)
    );

    sru_ring_rotator u_ring (
        .left (op == OP_ROLC),
        .src  (src_a),
        .amt  (ring_amt),
        .cin  (carry_q),
        .res  (ring_res)
    );

    always_comb begin
        unique case (op)
            OP_ROLC, OP_RORC: sel_res = ring_res;
            OP_PASS:          sel_res = '{value: src_a, carry: carry_q};
            default:          sel_res = plain_res;
        endcase
        result = sel_res.value;
        flag_c = sel_res.carry;
        flag_n = sel_res.value[DATA_W-1];
        flag_z = (sel_res.value == '0);
    end

    sru_carry_reg u_carry (
        .clk  (clk),
        .rst  (rst),
        .load (flag_we),
        .d    (flag_c),
        .q    (carry_q)
    );
endmodule

// File: rtl/sru_checker.sv
module sru_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_sel,
    input logic [31:0] src_a,
    input logic [31:0] amt_reg,
    input logic [5:0]  amt_imm,
    input logic        use_imm,
    input logic        flag_we,
    input logic [31:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_c,
    input logic        carry_q
);
    logic [31:0] raw;
    logic [4:0]  k;
    logic [31:0] low_mask;

    assign raw      = use_imm ? {26'b0, amt_imm} : amt_reg;
    assign k        = raw[4:0];
    assign low_mask = (32'd1 << k) - 32'd1;

    p_reset_clear_r10: assert property (@(posedge clk) rst |=> carry_q == 1'b0);

    p_carry_load_r9: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> carry_q == $past(flag_c));

    p_carry_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(carry_q));

    p_zero_amount_r7: assert property (@(posedge clk) disable iff (rst)
        (op_sel <= 3'd4 && k == 5'd0) |-> (result == src_a && flag_c == carry_q));

    p_lsl_fill_r1: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd0) |-> ((result & low_mask) == 32'd0));

    p_asr_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd2) |-> (result[31] == src_a[31]));

    p_pass_r11: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd7) |-> (result == src_a && flag_c == carry_q));

    p_flag_pair_r8: assert property (@(posedge clk) disable iff (rst)
        !(flag_n && flag_z));
endmodule

bind shift_rotate_unit sru_checker u_chk (.*);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] src_a = '0;
    logic [31:0] amt_reg = '0;
    logic [5:0]  amt_imm = '0;
    logic        use_imm = 1'b0;
    logic        flag_we = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, carry_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_carry = 1'b0;

    always #4 clk = ~clk;

    shift_rotate_unit u_dut (.*);

    function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic cin, input logic [31:0] raw);
        int k;
        logic c;
        logic [31:0] v;
        logic t;
        c = cin;
        v = a;
        if (op == 3'd5 || op == 3'd6) k = int'(raw % 32'd33);
        else if (op == 3'd7)          k = 0;
        else                          k = int'(raw[4:0]);
        for (int i = 0; i < k; i++) begin
            case (op)
                3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                3'd3: begin v = {v[30:0], v[31]}; c = v[0]; end
                3'd4: begin v = {v[0], v[31:1]};  c = v[31]; end
                3'd5: begin t = v[31]; v = {v[30:0], c}; c = t; end
                3'd6: begin t = v[0];  v = {c, v[31:1]}; c = t; end
                default: ;
            endcase
        end
        return {c, v};
    endfunction

    task automatic fail_line(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_fail++;
        $display("FAIL %s: actual %h expected %h", tag, act, exp);
    endtask

    // Drive one operation, check result and flags; optionally load the carry.
    task automatic vec(input string tag, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] areg, input logic [5:0] aimm, input logic sel,
                       input logic we);
        logic [32:0] e;
        logic [31:0] raw;
        @(negedge clk);
        op_sel = op; src_a = a; amt_reg = areg; amt_imm = aimm; use_imm = sel; flag_we = we;
        #1;
        raw = sel ? {26'b0, aimm} : areg;
        e = model(op, a, exp_carry, raw);
        n_checks++;
        if (result !== e[31:0] || flag_c !== e[32] || flag_n !== e[31] || flag_z !== (e[31:0] == 0))
            fail_line(tag, {29'b0, flag_c, flag_n, flag_z, result},
                      {29'b0, e[32], e[31], e[31:0] == 0, e[31:0]});
        if (we) exp_carry = e[32];
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    task automatic chk_carry(input string tag);
        #1;
        n_checks++;
        if (carry_q !== exp_carry) fail_line(tag, {63'b0, carry_q}, {63'b0, exp_carry});
    endtask

    task automatic set_carry(input logic v);
        vec("R9 set", 3'd0, v ? 32'h8000_0000 : 32'h0, 32'd0, 6'd1, 1'b1, 1'b1);
    endtask

    task automatic t_reset;
        set_carry(1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; exp_carry = 1'b0;
        chk_carry("R10 reset clears carry");
    endtask

    task automatic t_lsl;
        vec("R1 lsl by 2",   3'd0, 32'h0000_0007, 32'd2, 6'd0, 1'b0, 1'b0);
        vec("R1 lsl carry",  3'd0, 32'h4000_0001, 32'd2, 6'd0, 1'b0, 1'b0);
        vec("R1 lsl by 31",  3'd0, 32'hFFFF_FFFF, 32'd31, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_right;
        vec("R2 lsr",        3'd1, 32'h8000_0003, 32'd1, 6'd0, 1'b0, 1'b0);
        vec("R2 lsr by 31",  3'd1, 32'hC000_0000, 32'd31, 6'd0, 1'b0, 1'b0);
        vec("R3 asr neg",    3'd2, 32'h8000_0010, 32'd4, 6'd0, 1'b0, 1'b0);
        vec("R3 asr carry",  3'd2, 32'hF000_0008, 32'd4, 6'd0, 1'b0, 1'b0);
        vec("R3 asr pos",    3'd2, 32'h7000_0000, 32'd31, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_rotate;
        vec("R4 rol by 2",   3'd3, 32'hC000_0001, 32'd2, 6'd0, 1'b0, 1'b0);
        vec("R4 rol by 31",  3'd3, 32'h0000_0002, 32'd31, 6'd0, 1'b0, 1'b0);
        vec("R4 ror by 1",   3'd4, 32'h0000_0001, 32'd1, 6'd0, 1'b0, 1'b0);
        vec("R4 ror by 8",   3'd4, 32'h1234_5678, 32'd8, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_ring;
        set_carry(1'b1);
        vec("R5 rolc 1",     3'd5, 32'h8000_0000, 32'd1, 6'd0, 1'b0, 1'b0);
        vec("R5 rolc 32",    3'd5, 32'h0000_0001, 32'd32, 6'd0, 1'b0, 1'b0);
        vec("R5 rorc 1",     3'd6, 32'h0000_0001, 32'd1, 6'd0, 1'b0, 1'b0);
        vec("R5 rorc mod",   3'd6, 32'hA5A5_0F0F, 32'hFFFF_FFFF, 6'd0, 1'b0, 1'b0);
        vec("R5 rolc 33",    3'd5, 32'h1357_9BDF, 32'd33, 6'd0, 1'b0, 1'b0);
        vec("R5 rolc imm 34",3'd5, 32'h8000_0001, 32'd0, 6'd34, 1'b1, 1'b0);
        set_carry(1'b0);
        vec("R5 rorc c0",    3'd6, 32'h8000_0001, 32'd3, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_amount_src;
        vec("R6 imm used",   3'd0, 32'h0000_0001, 32'd9, 6'd4, 1'b1, 1'b0);
        vec("R6 reg used",   3'd0, 32'h0000_0001, 32'd9, 6'd4, 1'b0, 1'b0);
        vec("R6 low 5 bits", 3'd1, 32'hFFFF_0000, 32'h0000_0024, 6'd0, 1'b0, 1'b0);
        vec("R6 imm 33",     3'd3, 32'h8000_0000, 32'd0, 6'd33, 1'b1, 1'b0);
    endtask

    task automatic t_zero_amount;
        set_carry(1'b1);
        vec("R7 lsl zero",   3'd0, 32'hDEAD_BEEF, 32'd0, 6'd0, 1'b0, 1'b0);
        vec("R7 asr by 32",  3'd2, 32'h8000_0001, 32'd32, 6'd0, 1'b0, 1'b0);
        vec("R7 rorc 66",    3'd6, 32'h0F0F_0F0F, 32'd66, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_flags;
        vec("R8 zero result",3'd0, 32'h8000_0000, 32'd1, 6'd0, 1'b0, 1'b0);
        vec("R8 negative",   3'd4, 32'h0000_0001, 32'd1, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_carry_reg;
        set_carry(1'b1);
        chk_carry("R9 load on strobe");
        vec("R9 no strobe",  3'd1, 32'h0000_0002, 32'd1, 6'd0, 1'b0, 1'b0);
        chk_carry("R9 hold without strobe");
        vec("R9 load zero",  3'd1, 32'h0000_0002, 32'd1, 6'd0, 1'b0, 1'b1);
        chk_carry("R9 loaded zero");
    endtask

    task automatic t_reserved;
        set_carry(1'b1);
        vec("R11 pass c1",   3'd7, 32'h0000_0000, 32'd5, 6'd3, 1'b1, 1'b0);
        set_carry(1'b0);
        vec("R11 pass c0",   3'd7, 32'hF0F0_F0F0, 32'd5, 6'd3, 1'b0, 1'b0);
    endtask

    task automatic t_sweep;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int op = 0; op < 8; op++) begin
            for (int n = 0; n < 12; n++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                vec("R1 R2 R3 R4 R5 sweep", 3'(op), lfsr, {26'b0, lfsr[11:6]} + 32'(n),
                    lfsr[5:0], lfsr[17], lfsr[19]);
            end
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_carry = 1'b0;
        chk_carry("R10 reset state");
        t_lsl();
        t_right();
        t_rotate();
        t_ring();
        t_amount_src();
        t_zero_amount();
        t_flags();
        t_carry_reg();
        t_reserved();
        t_reset();
        t_sweep();
        finish_run();
    end

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule